// File: doc/BRIEF.md
# Radix-4 Signed-Digit Partial-Product Generator

This block turns an n-bit two's-complement multiplicand and one three-bit window of a radix-4 recoded multiplier into a single partial product. The result is a vector of signed binary digits, each worth -1, 0 or +1 at weight 2^k, whose value is 0, +A, +2A, -A or -2A. It has no clock and no state. The multiple is formed only by routing multiplicand bits to digit columns and choosing each digit's sign. There is no inversion-plus-one and no carry path, so every output digit depends on at most two multiplicand bits and the window.

A multiplier array places one instance per window, shifts instance j by 2j columns, and sums the partial products with carry-free signed-digit adders. For the lowest window the array ties the window's low bit to 0. Alignment and summation sit outside this block.

The window decoder maps the three bits onto five selection classes: `SEL_ZERO`, `SEL_POS1`, `SEL_POS2`, `SEL_NEG1` and `SEL_NEG2`. The mapping is a pure function of the window, so there are no transitions between classes.

Top module: `rbsd_ppgen`

## Requirements
- R1: With window bits written high to low as `win[2:0]`, the value of the output is 0 for 000 and 111, +A for 001 and 010, +2A for 011, -2A for 100, and -A for 101 and 110. A is the multiplicand read as signed.
- R2: For a single multiple (±A), multiplicand bit i lands in digit column i, and columns W and W+1 are zero. For a double multiple (±2A), bit i lands in column i+1, and column 0 is zero.
- R3: The digit taken from the multiplicand's sign bit (bit W-1) is given the opposite sign to the digits taken from the other bits. With A = 100000, window 001 puts -1 in column 5.
- R4: A negative multiple equals the matching positive multiple with the sign of every nonzero digit flipped. A clear multiplicand bit always gives a zero digit.
- R5: Digit k sits at `pp_digits[2k+1:2k]`. Code 00 is zero, 01 is +1 and 11 is -1. Zero has the single code 00, and code 10 is never produced.
- R6: The top column, W+1, is always zero.
- R7: Windows 000 and 111 give an output with every digit zero, whatever the multiplicand.
- R8: For multiplicand 110010 (-14), windows 110 and 101 give value +14 and window 011 gives value -28.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mcand | input | W (6) | Two's-complement multiplicand |
| win | input | 3 | Multiplier window: bits j+1, j, j-1 |
| pp_digits | output | 2*(W+2) (16) | Partial product, W+2 signed digits of 2 bits each |

## Verification
The hardest outputs to reach are the ones where the sign-bit inversion and the multiple's sign act together. Examples are a negative double multiple of a negative multiplicand, or the most negative multiplicand scaled by -2, which needs column W. Neither occurs unless window and multiplicand are swept jointly. The stimulus therefore walks every multiplicand against every window, 512 combinations at the default width. It then adds directed cases: the lone sign-bit multiplicand and the worked value 110010.

// File: rtl/rbsd_pkg.sv
package rbsd_pkg;

    // Signed digit code: bit 1 = negative, bit 0 = nonzero.
    typedef enum logic [1:0] {
        DIG_ZERO = 2'b00,
        DIG_POS  = 2'b01,
        DIG_NEG  = 2'b11
    } sdigit_t;

    // Selection classes produced by the window decoder.
    typedef enum logic [2:0] {
        SEL_ZERO = 3'd0,
        SEL_POS1 = 3'd1,
        SEL_POS2 = 3'd2,
        SEL_NEG1 = 3'd3,
        SEL_NEG2 = 3'd4
    } sel_class_t;

    typedef struct packed {
        logic is_zero;
        logic is_double;
        logic is_negative;
    } sel_ctrl_t;

endpackage

// File: rtl/rbsd_win_decode.sv
module rbsd_win_decode
    import rbsd_pkg::*;
(
    input  logic [2:0] win,
    output sel_class_t sel_class,
    output sel_ctrl_t  sel_ctrl
);

    always_comb begin
        unique case (win)
            3'b000, 3'b111: sel_class = SEL_ZERO;
            3'b001, 3'b010: sel_class = SEL_POS1;
            3'b011:         sel_class = SEL_POS2;
            3'b100:         sel_class = SEL_NEG2;
            3'b101, 3'b110: sel_class = SEL_NEG1;
            default:        sel_class = SEL_ZERO;
        endcase
    end

    always_comb begin
        sel_ctrl = '{is_zero: 1'b0, is_double: 1'b0, is_negative: 1'b0};
        unique case (sel_class)
            SEL_ZERO: sel_ctrl.is_zero = 1'b1;
            SEL_POS1: ;
            SEL_POS2: sel_ctrl.is_double = 1'b1;
            SEL_NEG1: sel_ctrl.is_negative = 1'b1;
            SEL_NEG2: begin
                sel_ctrl.is_double   = 1'b1;
                sel_ctrl.is_negative = 1'b1;
            end
            default:  sel_ctrl.is_zero = 1'b1;
        endcase
    end

endmodule

// File: rtl/rbsd_digit_cell.sv
module rbsd_digit_cell
    import rbsd_pkg::*;
#(
    parameter bit HERE_IS_SIGN  = 1'b0,
    parameter bit BELOW_IS_SIGN = 1'b0
) (
    input  logic      bit_here,
    input  logic      bit_below,
    input  sel_ctrl_t ctrl,
    output sdigit_t   digit
);

    logic src_bit;
    logic src_is_sign;
    logic flip;

    always_comb begin
        src_bit     = ctrl.is_double ? bit_below : bit_here;
        src_is_sign = ctrl.is_double ? BELOW_IS_SIGN : HERE_IS_SIGN;
        flip        = ctrl.is_negative ^ src_is_sign;
        if (ctrl.is_zero || !src_bit) begin
            digit = DIG_ZERO;
        end else if (flip) begin
            digit = DIG_NEG;
        end else begin
            digit = DIG_POS;
        end
    end

endmodule

// File: rtl/rbsd_ppgen.sv
module rbsd_ppgen
    import rbsd_pkg::*;
#(
    parameter int W = 6
) (
    input  logic [W-1:0]       mcand,
    input  logic [2:0]         win,
    output logic [2*(W+2)-1:0] pp_digits
);

    localparam int ND = W + 2;

    sel_class_t sel_class;
    sel_ctrl_t  sel_ctrl;
    logic [ND-1:0] a_here;
    logic [ND-1:0] a_below;

    assign a_here  = {2'b00, mcand};
    assign a_below = {1'b0, mcand, 1'b0};

    rbsd_win_decode u_dec (
        .win       (win),
        .sel_class (sel_class),
        .sel_ctrl  (sel_ctrl)
    );

    for (genvar k = 0; k < ND; k++) begin : g_col
        sdigit_t d;
        rbsd_digit_cell #(
            .HERE_IS_SIGN  (k == W - 1),
            .BELOW_IS_SIGN (k == W)
        ) u_cell (
            .bit_here  (a_here[k]),
            .bit_below (a_below[k]),
            .ctrl      (sel_ctrl),
            .digit     (d)
        );
        assign pp_digits[2*k +: 2] = d;
    end

endmodule

// File: rtl/rbsd_ppgen_chk.sv
module rbsd_ppgen_chk #(
    parameter int W = 6
) (
    input logic [W-1:0]       mcand,
    input logic [2:0]         win,
    input logic [2*(W+2)-1:0] pp_digits
);

    localparam int ND = W + 2;

    function automatic int digits_value(input logic [2*ND-1:0] v);
        int acc = 0;
        for (int k = 0; k < ND; k++) begin
            if (v[2*k +: 2] == 2'b01) acc += (1 << k);
            else if (v[2*k +: 2] == 2'b11) acc -= (1 << k);
        end
        return acc;
    endfunction

    function automatic int window_factor(input logic [2:0] w);
        case (w)
            3'b001, 3'b010: return 1;
            3'b011:         return 2;
            3'b100:         return -2;
            3'b101, 3'b110: return -1;
            default:        return 0;
        endcase
    endfunction

    always_comb begin
        if (!$isunknown({mcand, win, pp_digits})) begin
            a_r1_value_matches: assert (digits_value(pp_digits) ==
                window_factor(win) * int'($signed(mcand)));
            for (int k = 0; k < ND; k++) begin
                a_r5_no_code_10: assert (pp_digits[2*k +: 2] != 2'b10);
            end
            a_r6_top_zero: assert (pp_digits[2*ND-1 -: 2] == 2'b00);
            if (win == 3'b000 || win == 3'b111) begin
                a_r7_zero_window: assert (pp_digits == '0);
            end
            if (win == 3'b011 || win == 3'b100) begin
                a_r2_low_empty_dbl: assert (pp_digits[1:0] == 2'b00);
            end
            if (win inside {3'b001, 3'b010, 3'b101, 3'b110}) begin
                a_r2_high_empty_sgl: assert (pp_digits[2*W +: 2] == 2'b00);
            end
        end
    end

endmodule

bind rbsd_ppgen rbsd_ppgen_chk #(.W(W)) u_chk (
    .mcand     (mcand),
    .win       (win),
    .pp_digits (pp_digits)
);

// File: tb/tb_rbsd_ppgen.sv
module tb_rbsd_ppgen;

    localparam int CLK_PERIOD = 10;
    localparam int W  = 6;
    localparam int ND = W + 2;
    localparam int WATCHDOG_CYCLES = 20000;

    typedef struct {
        logic [2*ND-1:0] exp_vec;
        int              exp_val;
        string           tag;
    } item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [W-1:0] mcand = '0;
    logic [2:0]   win   = 3'b000;
    logic [2*ND-1:0] pp_digits;

    item_t sb_q[$];
    int checks = 0;
    int failures = 0;
    bit drive_done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rbsd_ppgen #(.W(W)) dut (
        .mcand     (mcand),
        .win       (win),
        .pp_digits (pp_digits)
    );

    function automatic int factor_of(input logic [2:0] w);
        case (w)
            3'b001, 3'b010: return 1;
            3'b011:         return 2;
            3'b100:         return -2;
            3'b101, 3'b110: return -1;
            default:        return 0;
        endcase
    endfunction

    // Expected digit layout from R2/R3/R4/R5.
    function automatic logic [2*ND-1:0] layout_of(input logic [W-1:0] a, input logic [2:0] w);
        logic [2*ND-1:0] v = '0;
        int f = factor_of(w);
        int shift = (f == 2 || f == -2) ? 1 : 0;
        bit neg = (f < 0);
        if (f != 0) begin
            for (int i = 0; i < W; i++) begin
                if (a[i]) begin
                    v[2*(i+shift) +: 2] = ((neg ^ (i == W-1)) != 0) ? 2'b11 : 2'b01;
                end
            end
        end
        return v;
    endfunction

    function automatic int value_of(input logic [2*ND-1:0] v);
        int acc = 0;
        for (int k = 0; k < ND; k++) begin
            if (v[2*k +: 2] == 2'b01) acc += (1 << k);
            else if (v[2*k +: 2] == 2'b11) acc -= (1 << k);
        end
        return acc;
    endfunction

    task automatic note_check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic drive(input logic [W-1:0] a, input logic [2:0] w, input string tag);
        item_t it;
        @(negedge clk);
        mcand = a;
        win   = w;
        it.exp_vec = layout_of(a, w);
        it.exp_val = factor_of(w) * int'($signed(a));
        it.tag     = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: inputs change on negedge only; sample on posedge.
    always @(posedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            bit bad_code;
            it = sb_q.pop_front();
            note_check(value_of(pp_digits) == it.exp_val,
                       {it.tag, " R1 value"}, value_of(pp_digits), it.exp_val);
            note_check(pp_digits == it.exp_vec,
                       {it.tag, " R2/R4 layout"}, int'(pp_digits), int'(it.exp_vec));
            bad_code = 1'b0;
            for (int k = 0; k < ND; k++) if (pp_digits[2*k +: 2] == 2'b10) bad_code = 1'b1;
            note_check(!bad_code, {it.tag, " R5 code 10 absent"}, int'(bad_code), 0);
            note_check(pp_digits[2*ND-1 -: 2] == 2'b00,
                       {it.tag, " R6 top zero"}, int'(pp_digits[2*ND-1 -: 2]), 0);
        end
    end

    initial begin
        // reset state: zero inputs give an all-zero output
        repeat (2) @(negedge clk);
        note_check(pp_digits == '0, "reset R7 zero output", int'(pp_digits), 0);
        rst = 1'b0;

        // R1 R2: every multiplicand against every window
        for (int a = 0; a < (1 << W); a++) begin
            for (int w = 0; w < 8; w++) begin
                drive(W'(a), 3'(w), "R1 sweep");
            end
        end

        // R3: lone sign bit, positive single multiple
        drive(6'b100000, 3'b001, "R3");
        @(posedge clk); #1;
        note_check(pp_digits[2*5 +: 2] == 2'b11, "R3 sign digit negative",
                   int'(pp_digits[2*5 +: 2]), 3);

        // R4: negation flips every nonzero digit
        drive(6'b010101, 3'b101, "R4");
        @(posedge clk); #1;
        note_check(pp_digits == 16'h0333, "R4 flipped digits", int'(pp_digits), 16'h0333);

        // R7: zero windows with a busy multiplicand
        drive(6'b111111, 3'b111, "R7");
        @(posedge clk); #1;
        note_check(pp_digits == '0, "R7 window 111", int'(pp_digits), 0);
        drive(6'b101101, 3'b000, "R7");
        @(posedge clk); #1;
        note_check(pp_digits == '0, "R7 window 000", int'(pp_digits), 0);

        // R8: worked multiplicand 110010 (-14)
        drive(6'b110010, 3'b110, "R8");
        @(posedge clk); #1;
        note_check(value_of(pp_digits) == 14, "R8 window 110", value_of(pp_digits), 14);
        drive(6'b110010, 3'b101, "R8");
        @(posedge clk); #1;
        note_check(value_of(pp_digits) == 14, "R8 window 101", value_of(pp_digits), 14);
        drive(6'b110010, 3'b011, "R8");
        @(posedge clk); #1;
        note_check(value_of(pp_digits) == -28, "R8 window 011", value_of(pp_digits), -28);

        // R2: most negative multiplicand doubled needs column W
        drive(6'b100000, 3'b100, "R2 extreme");
        @(posedge clk); #1;
        note_check(value_of(pp_digits) == 64, "R2 -2 x -32", value_of(pp_digits), 64);

        while (sb_q.size() > 0) @(negedge clk);
        drive_done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!drive_done && cyc < WATCHDOG_CYCLES) begin
            @(negedge clk);
            cyc++;
        end
        if (!drive_done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, WATCHDOG_CYCLES);
        end
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule